// File: doc/BRIEF.md
# Selectable Divide-by-1/2 Gated Clock Stage

This block conditions one incoming clock into a true output and a complement output. The incoming clock is treated as a data signal and sampled by a faster system clock, so the whole stage works in one synchronous domain. Edges are detected from consecutive samples. A divide select picks one of two modes. In pass-through mode the outputs follow the incoming clock level. In divide mode they toggle once per rising incoming edge, which gives half the rate at a 50% duty cycle.

A separate enable gates the outputs. A two-bit mode code sets how the enable is read: its polarity, and what a floating (unconnected) enable pin means. The enable is taken only on falling incoming edges, so turning the stage on or off never shortens a pulse. While the stage is disabled, both outputs sit low together and the divider is held cleared. Because of this, the outputs of several stages can be OR-ed onto one shared line, where only the enabled stage drives it.

Top module: `gck_div12_stage`

## Requirements
- R1: While rst_n is low at a rising clk edge, the block is left disabled, in pass-through mode, with the divider cleared; after that edge q_true and q_comp are both 0.
- R2: With div_sel=0 applied and enabled, after each clk edge q_true equals ck_in as sampled at that edge and q_comp is its inverse.
- R3: In divide mode (div_sel=1) and enabled, q_true inverts at every rising ck_in edge (0 then 1 in consecutive samples) and holds otherwise; q_comp is its inverse.
- R4: While disabled, q_true and q_comp are both 0.
- R5: en_mode codes: 2'b00 = enable active high, floating (en_float=1) means enabled; 2'b01 = active high, floating means disabled; 2'b10 = active low, floating means enabled. When en_float=1, en_pin is ignored.
- R6: en_mode 2'b11 behaves exactly like 2'b00 and drives cfg_err to 1; cfg_err is 0 for every other code.
- R7: The decoded enable is taken only at a falling ck_in edge (a 1 sample followed by a 0 sample); an enable change between falling edges does not affect the outputs until the next one.
- R8: The divider is cleared while disabled, so the first rising ck_in edge after enabling in divide mode drives q_true to 1.
- R9: A div_sel change takes effect at the next rising ck_in edge; on entry to divide mode q_true goes to 1 at that edge, and on leaving it the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ck_in | input | 1 | Incoming clock, sampled as data |
| div_sel | input | 1 | 0 = pass-through, 1 = divide by two |
| en_pin | input | 1 | Enable level |
| en_float | input | 1 | 1 = enable pin is unconnected |
| en_mode | input | 2 | Enable interpretation code |
| q_true | output | 1 | True clock output |
| q_comp | output | 1 | Complement clock output |
| cfg_err | output | 1 | Reserved enable code in use |

## Verification
The bench changes the enable in the middle of an incoming high phase and checks that the output stays high until the falling edge. A design that gated the enable directly would cut that pulse short. It disables and re-enables the stage in divide mode and checks that the first rising edge gives a high output. A divider that was not held cleared would restart with the wrong phase, and a design that failed to force both outputs low would leave the complement high on a shared line. It steps through every enable code with the pin both floating and driven, including the reserved code. It also switches the divide select mid-stream, where a design applying the change immediately would glitch the output.

// File: rtl/gck_pkg.sv
// Shared types for the gated clock stage.
// Assumes: two-bit enable interpretation code.
package gck_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ENM_HI_ON  = 2'b00,   // active high, floating = enabled
        ENM_HI_OFF = 2'b01,   // active high, floating = disabled
        ENM_LO_ON  = 2'b10,   // active low, floating = enabled
        ENM_RSVD   = 2'b11    // unused, handled as ENM_HI_ON
    } en_mode_e;
endpackage

// File: rtl/gck_en_decode.sv
// Turns the enable pin, its floating flag and the mode code into one raw
// enable level. Purely combinational.
// Assumes: the reserved code behaves like the active-high default-on code.
module gck_en_decode
    import gck_pkg::*;
(
    input  logic              en_pin,
    input  logic              en_float,
    input  logic [MODE_W-1:0] en_mode,
    output logic              en_raw,
    output logic              cfg_err
);
    // Decode polarity and floating default per mode code.
    always_comb begin
        cfg_err = 1'b0;
        unique case (en_mode_e'(en_mode))
            ENM_HI_OFF: en_raw = en_float ? 1'b0 : en_pin;
            ENM_LO_ON:  en_raw = en_float ? 1'b1 : ~en_pin;
            ENM_RSVD: begin
                en_raw  = en_float ? 1'b1 : en_pin;
                cfg_err = 1'b1;
            end
            default:    en_raw = en_float ? 1'b1 : en_pin;
        endcase
    end

    // R5: a floating pin under the default-off code never enables
    always_comb begin
        if (en_float && en_mode == ENM_HI_OFF)
            p_float_off_r5: assert (!en_raw);
    end
endmodule

// File: rtl/gck_edge_track.sv
// Samples the incoming clock once per system clock and flags its edges.
// Assumes: each incoming half period lasts at least one system clock.
module gck_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_in,
    output logic lvl_q,
    output logic rise,
    output logic fall
);
    // Hold the previous sample of the incoming clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= ck_in;
    end

    // Compare the live input with the held sample to find edges.
    always_comb begin
        rise = ck_in & ~lvl_q;
        fall = ~ck_in & lvl_q;
    end
endmodule

// File: rtl/gck_en_sampler.sv
// Takes the decoded enable only on falling incoming edges so that no
// output pulse is shortened.
// Assumes: fall is a single-cycle pulse from the edge tracker.
module gck_en_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic en_raw,
    output logic en_q
);
    // Capture the enable on a falling incoming edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= 1'b0;
        else if (fall) en_q <= en_raw;
    end

    // R7: the enable never moves outside a falling edge
    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(en_q));
endmodule

// File: rtl/gck_half_div.sv
// Divide-by-two toggle plus the registered mode select.
// Assumes: rise is a single-cycle pulse; the toggle is cleared while disabled.
module gck_half_div (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic en_q,
    input  logic div_sel,
    output logic mode_q,
    output logic tgl_q
);
    // Latch the divide select on a rising incoming edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= 1'b0;
        else if (rise) mode_q <= div_sel;
    end

    // Toggle on rising edges in divide mode, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) tgl_q <= 1'b0;
        else if (rise)       tgl_q <= div_sel ? ~tgl_q : 1'b0;
    end
endmodule

// File: rtl/gck_div12_stage.sv
// Top of the gated divide-by-1/2 clock stage: edge tracker, enable
// decoder, falling-edge enable sampler, divider and output gating.
// Assumes: ck_in is slower than clk by at least a factor of two.
module gck_div12_stage
    import gck_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ck_in,
    input  logic              div_sel,
    input  logic              en_pin,
    input  logic              en_float,
    input  logic [MODE_W-1:0] en_mode,
    output logic              q_true,
    output logic              q_comp,
    output logic              cfg_err
);
    logic lvl_q, rise, fall, en_raw, en_q, mode_q, tgl_q;

    gck_edge_track u_edge (
        .clk(clk), .rst_n(rst_n), .ck_in(ck_in),
        .lvl_q(lvl_q), .rise(rise), .fall(fall));

    gck_en_decode u_dec (
        .en_pin(en_pin), .en_float(en_float), .en_mode(en_mode),
        .en_raw(en_raw), .cfg_err(cfg_err));

    gck_en_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .fall(fall),
        .en_raw(en_raw), .en_q(en_q));

    gck_half_div u_div (
        .clk(clk), .rst_n(rst_n), .rise(rise), .en_q(en_q),
        .div_sel(div_sel), .mode_q(mode_q), .tgl_q(tgl_q));

    // Pick the source per mode and force both outputs low when disabled.
    always_comb begin
        q_true = en_q & (mode_q ? tgl_q  : lvl_q);
        q_comp = en_q & (mode_q ? ~tgl_q : ~lvl_q);
    end

    // R2: pass-through output follows the last sample of ck_in
    p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !mode_q) |-> (q_true == $past(ck_in)));

    // R3: each rising edge in steady divide mode flips the true output
    p_div_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && en_q && div_sel && mode_q) |=> (q_true != $past(q_true)));

    // R9: entering divide mode drives the true output high
    p_entry_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && en_q && div_sel && !mode_q) |=> q_true);

    // R4: disabled stage shows both outputs low
    p_dis_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !en_q) |=> (!q_true && !q_comp));
endmodule

// File: tb/sim_gck_div12_stage.sv
`timescale 1ns/1ps
module sim_gck_div12_stage;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n, ck_in, div_sel, en_pin, en_float;
    logic [1:0] en_mode;
    logic       q_true, q_comp, cfg_err;

    gck_div12_stage u0 (
        .clk(clk), .rst_n(rst_n), .ck_in(ck_in), .div_sel(div_sel),
        .en_pin(en_pin), .en_float(en_float), .en_mode(en_mode),
        .q_true(q_true), .q_comp(q_comp), .cfg_err(cfg_err));

    // reference state built from the requirements
    logic m_lvl, m_en, m_mode, m_t;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    string      cur_tag;
    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    function automatic logic ref_en(logic p, logic f, logic [1:0] m);
        case (m)
            2'b01:   return f ? 1'b0 : p;
            2'b10:   return f ? 1'b1 : ~p;
            default: return f ? 1'b1 : p;   // 00 and reserved 11
        endcase
    endfunction

    // driver: predict the state after the coming clk edge and queue it
    task automatic cyc();
        logic r, f, nt;
        r = ck_in & ~m_lvl;
        f = ~ck_in & m_lvl;
        if (!rst_n) begin
            m_lvl = 0; m_en = 0; m_mode = 0; m_t = 0;
        end else begin
            nt = !m_en ? 1'b0 : (r ? (div_sel ? ~m_t : 1'b0) : m_t);
            if (f) m_en = ref_en(en_pin, en_float, en_mode);
            if (r) m_mode = div_sel;
            m_t = nt;
            m_lvl = ck_in;
        end
        exp_q.push_back({m_en & (m_mode ? m_t : m_lvl),
                         m_en & (m_mode ? ~m_t : ~m_lvl),
                         en_mode == 2'b11});
        tag_q.push_back(cur_tag);
        @(negedge clk);
    endtask

    task automatic hold(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic run(int halves, int h);
        for (int i = 0; i < halves; i++) begin
            ck_in = ~ck_in;
            hold(h);
        end
    endtask

    // monitor: compare each queued prediction after its clk edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({q_true, q_comp, cfg_err} !== e) begin
                bad++;
                $display("FAIL %s: {q_true,q_comp,cfg_err} got=%b exp=%b",
                         t, {q_true, q_comp, cfg_err}, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ck_in = 0; div_sel = 0; en_pin = 0; en_float = 0;
        en_mode = 2'b00;
        m_lvl = 0; m_en = 0; m_mode = 0; m_t = 0;
        @(negedge clk);
        cur_tag = "R1 reset";        hold(3);
        rst_n = 1;
        cur_tag = "R2 pass";  en_pin = 1; run(8, 3);
        cur_tag = "R2 pass fast";    run(6, 1);
        // R7: drop enable during a high phase, output must stay high
        cur_tag = "R7 late disable"; ck_in = 1; hold(1); en_pin = 0; hold(2);
        ck_in = 0; hold(3);
        cur_tag = "R4 disabled";     run(4, 3);
        cur_tag = "R7 late enable";  en_pin = 1; hold(2); run(4, 3);
        cur_tag = "R9 enter div";    div_sel = 1; run(2, 3);
        cur_tag = "R3 divide";       run(8, 3);
        cur_tag = "R8 div disabled"; en_pin = 0; run(4, 3);
        cur_tag = "R8 div restart";  en_pin = 1; run(6, 3);
        cur_tag = "R9 leave div";    div_sel = 0; hold(1); run(4, 3);
        cur_tag = "R9 reenter div";  ck_in = ~ck_in; hold(2); div_sel = 1;
        hold(1); run(5, 2);
        div_sel = 0;
        cur_tag = "R5 00 float";     en_float = 1; en_pin = 0; run(4, 3);
        cur_tag = "R5 01 float";     en_mode = 2'b01; run(4, 3);
        cur_tag = "R5 01 driven";    en_float = 0; en_pin = 1; run(4, 3);
        cur_tag = "R5 10 float";     en_mode = 2'b10; en_float = 1; run(4, 3);
        cur_tag = "R5 10 low";       en_float = 0; en_pin = 0; run(4, 3);
        cur_tag = "R5 10 high";      en_pin = 1; run(4, 3);
        cur_tag = "R6 11 driven low"; en_mode = 2'b11; en_pin = 0; run(4, 3);
        cur_tag = "R6 11 float";     en_float = 1; run(4, 3);
        cur_tag = "R6 back to 00";   en_mode = 2'b00; run(2, 3);
        @(posedge clk); #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule